// File: doc/BRIEF.md
# Card Clock Generator with Flow-Control Gating

This block derives the serial clock of a memory-card host port from the system master clock. A divide field sets the normal card rate. When low-power operation is requested, a second, cascaded divide factor slows the clock further. Separate stall enables for reads and writes let the block hold the card clock in its low phase while the local data FIFO cannot take or give data. This protects data integrity at the cost of bandwidth.

Alongside the clock, the block drives one-cycle strobes that coincide with every rising and falling card-clock transition. The shift logic for commands and data uses these strobes. New divider settings are sampled only at a period boundary, which is the rising transition. This keeps every high and low phase whole.

Top module: `card_clk_gen`

## Requirements
- R1: With low-power mode inactive, the card clock period is 2*(div_i+1) master-clock cycles, with equal high and low phases of div_i+1 cycles each. div_i=255 gives a period of 512.
- R2: With lp_en_i=1 and lp_div_i nonzero, the period is 2*(div_i+1)*(2^lp_div_i+1) master cycles.
- R3: A low-power request with lp_div_i=0 is ignored, and the period stays 2*(div_i+1).
- R4: With rd_hold_en_i=1, xfer_active_i=1 and xfer_dir_i=0 (read), the card clock is held low and no rising edge occurs while fifo_full_i=1. The clock rises again once fifo_full_i drops.
- R5: With wr_hold_en_i=1, xfer_active_i=1 and xfer_dir_i=1 (write), the card clock is held low while fifo_empty_i=1. It resumes after fifo_empty_i drops.
- R6: A hold condition whose enable is clear, or whose direction does not match, has no effect, and the clock keeps running.
- R7: A hold never shortens a high phase. A hold raised while the clock is high takes effect only after the full high phase and the falling edge.
- R8: Divider and low-power settings are sampled only at a rising card-clock edge. A change during a period leaves that period's length unchanged, and the following period uses the new value.
- R9: rise_o and fall_o are each one master cycle wide, are set exactly in the cycle in which card_clk_o first shows its new level, are never set together, and stay low while the clock is held.
- R10: After reset, card_clk_o, rise_o and fall_o are 0, and the stored half period is 1 master cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Normal-rate divide field |
| lp_div_i | input | LP_W | Low-power exponent field |
| lp_en_i | input | 1 | Low-power mode request |
| rd_hold_en_i | input | 1 | Allow holding the clock on a full FIFO during reads |
| wr_hold_en_i | input | 1 | Allow holding the clock on an empty FIFO during writes |
| xfer_active_i | input | 1 | Data transfer in progress |
| xfer_dir_i | input | 1 | Transfer direction, 0 read, 1 write |
| fifo_full_i | input | 1 | Receive FIFO full |
| fifo_empty_i | input | 1 | Transmit FIFO empty |
| card_clk_o | output | 1 | Card clock |
| rise_o | output | 1 | One-cycle strobe on a card clock rising edge |
| fall_o | output | 1 | One-cycle strobe on a card clock falling edge |

## Verification
The bench builds the block with its default widths: an 8-bit divide field and a 3-bit low-power exponent. With these widths the slowest normal rate of 512 cycles per period can be measured directly, and so can low-power factors of 3 and 5 on a small divider. Because the exponent is narrow, the largest low-power product stays inside the counter width. Keeping div_i small during the hold tests makes whole high phases short enough to count exactly against a hold raised mid-phase.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic clk;
        logic rise;
        logic fall;
    } edge_state_t;

endpackage

// File: rtl/card_clk_half.sv
module card_clk_half #(
    parameter int DIV_W  = 8,
    parameter int LP_W   = 3,
    parameter int HALF_W = 17
) (
    input  logic [DIV_W-1:0]  div_i,
    input  logic [LP_W-1:0]   lp_div_i,
    input  logic              lp_en_i,
    output logic [HALF_W-1:0] half_o
);
    logic              lp_active;
    logic [HALF_W-1:0] base;
    logic [HALF_W-1:0] factor;

    // Low-power mode counts only with a nonzero exponent
    assign lp_active = lp_en_i && (lp_div_i != '0);

    always_comb begin
        base   = HALF_W'(div_i) + HALF_W'(1);
        factor = lp_active ? ((HALF_W'(1) << lp_div_i) + HALF_W'(1)) : HALF_W'(1);
        half_o = HALF_W'(base * factor);
    end
endmodule

// File: rtl/card_clk_hold.sv
module card_clk_hold
    import card_clk_pkg::*;
(
    input  logic rd_hold_en_i,
    input  logic wr_hold_en_i,
    input  logic xfer_active_i,
    input  logic xfer_dir_i,
    input  logic fifo_full_i,
    input  logic fifo_empty_i,
    output logic hold_o
);
    xfer_dir_e dir;
    logic      rd_hold;
    logic      wr_hold;

    assign dir     = xfer_dir_e'(xfer_dir_i);
    assign rd_hold = rd_hold_en_i && (dir == DIR_READ)  && fifo_full_i;
    assign wr_hold = wr_hold_en_i && (dir == DIR_WRITE) && fifo_empty_i;
    assign hold_o  = xfer_active_i && (rd_hold || wr_hold);
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import card_clk_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LP_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic [LP_W-1:0]  lp_div_i,
    input  logic             lp_en_i,
    input  logic             rd_hold_en_i,
    input  logic             wr_hold_en_i,
    input  logic             xfer_active_i,
    input  logic             xfer_dir_i,
    input  logic             fifo_full_i,
    input  logic             fifo_empty_i,
    output logic             card_clk_o,
    output logic             rise_o,
    output logic             fall_o
);
    localparam int LP_MAX = (1 << LP_W) - 1;
    localparam int HALF_W = DIV_W + LP_MAX + 2;

    typedef struct packed {
        edge_state_t       edg;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] half;
    } gen_state_t;

    gen_state_t        st_d, st_q;
    logic [HALF_W-1:0] half_next;
    logic              hold;
    logic              frozen;
    logic              phase_end;

    card_clk_half #(
        .DIV_W  (DIV_W),
        .LP_W   (LP_W),
        .HALF_W (HALF_W)
    ) u_half (
        .div_i    (div_i),
        .lp_div_i (lp_div_i),
        .lp_en_i  (lp_en_i),
        .half_o   (half_next)
    );

    card_clk_hold u_hold (
        .rd_hold_en_i  (rd_hold_en_i),
        .wr_hold_en_i  (wr_hold_en_i),
        .xfer_active_i (xfer_active_i),
        .xfer_dir_i    (xfer_dir_i),
        .fifo_full_i   (fifo_full_i),
        .fifo_empty_i  (fifo_empty_i),
        .hold_o        (hold)
    );

    // Freeze only in the low phase; high phases always run to completion
    assign frozen    = hold && !st_q.edg.clk;
    assign phase_end = (st_q.cnt == st_q.half - HALF_W'(1));

    always_comb begin
        st_d          = st_q;
        st_d.edg.rise = 1'b0;
        st_d.edg.fall = 1'b0;
        if (!frozen) begin
            if (phase_end) begin
                st_d.cnt      = '0;
                st_d.edg.clk  = !st_q.edg.clk;
                st_d.edg.rise = !st_q.edg.clk;
                st_d.edg.fall = st_q.edg.clk;
                // New period starts at a rising edge: sample settings here
                if (!st_q.edg.clk) begin
                    st_d.half = half_next;
                end
            end else begin
                st_d.cnt = st_q.cnt + HALF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.edg  <= '0;
            st_q.cnt  <= '0;
            st_q.half <= HALF_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign card_clk_o = st_q.edg.clk;
    assign rise_o     = st_q.edg.rise;
    assign fall_o     = st_q.edg.fall;
endmodule

// File: rtl/card_clk_gen_chk.sv
module card_clk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_hold_en_i,
    input logic wr_hold_en_i,
    input logic xfer_active_i,
    input logic xfer_dir_i,
    input logic fifo_full_i,
    input logic fifo_empty_i,
    input logic card_clk_o,
    input logic rise_o,
    input logic fall_o
);
    logic rd_stall;
    logic wr_stall;

    assign rd_stall = rd_hold_en_i && xfer_active_i && !xfer_dir_i && fifo_full_i;
    assign wr_stall = wr_hold_en_i && xfer_active_i && xfer_dir_i && fifo_empty_i;

    AST_RD_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stall && !card_clk_o) |=> (!card_clk_o && !rise_o)); // R4
    AST_WR_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stall && !card_clk_o) |=> (!card_clk_o && !rise_o)); // R5
    AST_RISE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $rose(card_clk_o)); // R9
    AST_FALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $fell(card_clk_o)); // R9
    AST_EDGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(card_clk_o) || $fell(card_clk_o)) |-> (rise_o || fall_o)); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o})); // R9
endmodule

bind card_clk_gen card_clk_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_hold_en_i  (rd_hold_en_i),
    .wr_hold_en_i  (wr_hold_en_i),
    .xfer_active_i (xfer_active_i),
    .xfer_dir_i    (xfer_dir_i),
    .fifo_full_i   (fifo_full_i),
    .fifo_empty_i  (fifo_empty_i),
    .card_clk_o    (card_clk_o),
    .rise_o        (rise_o),
    .fall_o        (fall_o)
);

// File: tb/sim_card_clk_gen.sv
`timescale 1ns/1ps
module sim_card_clk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_i = '0;
    logic [2:0] lp_div_i = '0;
    logic       lp_en_i = 1'b0;
    logic       rd_hold_en_i = 1'b0;
    logic       wr_hold_en_i = 1'b0;
    logic       xfer_active_i = 1'b0;
    logic       xfer_dir_i = 1'b0;
    logic       fifo_full_i = 1'b0;
    logic       fifo_empty_i = 1'b0;
    logic       card_clk_o, rise_o, fall_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    card_clk_gen u0 (
        .clk (clk), .rst_n (rst_n), .div_i (div_i), .lp_div_i (lp_div_i),
        .lp_en_i (lp_en_i), .rd_hold_en_i (rd_hold_en_i), .wr_hold_en_i (wr_hold_en_i),
        .xfer_active_i (xfer_active_i), .xfer_dir_i (xfer_dir_i),
        .fifo_full_i (fifo_full_i), .fifo_empty_i (fifo_empty_i),
        .card_clk_o (card_clk_o), .rise_o (rise_o), .fall_o (fall_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (!rise_o);
    endtask

    // Rise-to-rise period; call right after wait_rise
    task automatic measure(output int period, output int high);
        period = 0;
        high   = 1;
        do begin
            @(negedge clk);
            period++;
            if (card_clk_o && period == high) high++;
        end while (!rise_o && period < 5000);
    endtask

    task automatic set_div(input int d, input int p, input bit lp);
        div_i    = 8'(d);
        lp_div_i = 3'(p);
        lp_en_i  = lp;
        wait_rise();
        wait_rise();
    endtask

    task automatic t_reset();
        check("R10 clk", int'(card_clk_o), 0);
        check("R10 strobes", int'(rise_o | fall_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 first half", int'(card_clk_o), 1);
    endtask

    task automatic t_normal();
        int per, hi;
        set_div(0, 0, 0);
        measure(per, hi);
        check("R1 div0 period", per, 2);
        set_div(3, 0, 0);
        measure(per, hi);
        check("R1 div3 period", per, 8);
        check("R1 div3 high", hi, 4);
        set_div(255, 0, 0);
        measure(per, hi);
        check("R1 div255 period", per, 512);
    endtask

    task automatic t_lowpower();
        int per, hi;
        set_div(1, 1, 1);
        measure(per, hi);
        check("R2 lp1 period", per, 12);
        set_div(1, 2, 1);
        measure(per, hi);
        check("R2 lp2 period", per, 20);
        set_div(1, 0, 1);
        measure(per, hi);
        check("R3 lp zero ignored", per, 4);
        lp_en_i = 1'b0;
    endtask

    task automatic t_change();
        int per, hi;
        set_div(3, 0, 0);
        div_i = 8'd0;
        measure(per, hi);
        check("R8 old period kept", per, 8);
        measure(per, hi);
        check("R8 new period used", per, 2);
    endtask

    task automatic hold_run(input string req, input bit wr);
        int hi, strobes;
        set_div(3, 0, 0);
        xfer_active_i = 1'b1;
        xfer_dir_i    = wr;
        rd_hold_en_i  = !wr;
        wr_hold_en_i  = wr;
        fifo_full_i   = !wr;
        fifo_empty_i  = wr;
        hi = 1;
        @(negedge clk);
        while (card_clk_o) begin hi++; @(negedge clk); end
        check({req, " R7 high kept"}, hi, 4);
        strobes = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (card_clk_o) strobes += 100;
            if (rise_o || fall_o) strobes++;
        end
        check({req, " held low R9"}, strobes, 0);
        fifo_full_i  = 1'b0;
        fifo_empty_i = 1'b0;
        hi = 0;
        while (!rise_o && hi < 20) begin @(negedge clk); hi++; end
        check({req, " resumes"}, hi, 4);
        rd_hold_en_i = 1'b0;
        wr_hold_en_i = 1'b0;
    endtask

    task automatic t_hold();
        wait_rise();
        hold_run("R4", 1'b0);
        wait_rise();
        hold_run("R5", 1'b1);
    endtask

    task automatic t_nohold();
        int per, hi;
        set_div(1, 0, 0);
        xfer_active_i = 1'b1;
        fifo_full_i   = 1'b1;
        fifo_empty_i  = 1'b1;
        xfer_dir_i    = 1'b0;
        wait_rise();
        measure(per, hi);
        check("R6 no enable", per, 4);
        rd_hold_en_i = 1'b1;
        xfer_dir_i   = 1'b1;
        wait_rise();
        measure(per, hi);
        check("R6 dir mismatch", per, 4);
        rd_hold_en_i  = 1'b0;
        xfer_active_i = 1'b0;
        fifo_full_i   = 1'b0;
        fifo_empty_i  = 1'b0;
    endtask

    task automatic t_strobe_width();
        int w;
        set_div(2, 0, 0);
        w = 0;
        do begin w++; @(negedge clk); end while (rise_o);
        check("R9 rise width", w, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_normal();
        t_lowpower();
        t_change();
        t_hold();
        t_nohold();
        t_strobe_width();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule